// File: doc/BRIEF.md
# Processor Clock Throttle Controller

This block slows a processor by modulating one active-low stop-clock pin. It does not change the supply voltage or the clock frequency. Software programs a single 32-bit control word through a plain write strobe and a read-back bus. The word holds an enable flag at bit 4 and a duty field whose position and size are set when the block is elaborated. While throttling is on, the block splits time into periods of 2^DUTY_W slots. Each slot lasts SLOT_CYC clocks. The processor runs in the leading slots of each period, and the stop-clock pin is driven low in the remaining slots.

A new setting is applied in three writes:

1. Clear the enable flag.
2. Store the new duty with the enable flag still clear.
3. Set the enable flag.

A duty value is only picked up at a period boundary, so no period is ever cut short or stretched by a write. Clearing the enable flag releases the pin on the following clock. The elaboration fails if the parameters place the duty field past bit 31 or over bit 4. A duty width of zero builds a block with no throttling: the pin stays high, but the register remains readable.

Top module: `clk_throttle`

## Requirements
- R1: After reset the control word reads 0x00000000 and `stopClkN` is 1.
- R2: A cycle with `wrEn` high stores all 32 bits of `wrData`. From the next cycle `rdData` returns them unchanged, including bits outside the enable flag and the duty field. The duty field occupies bits [DUTY_OFS+DUTY_W-1:DUTY_OFS].
- R3: When `rdData[4]` (enable) is 0 during a cycle, `stopClkN` is 1 in the following cycle.
- R4: A slot counter and a cycle counter run freely from reset, and a period spans 2^DUTY_W × SLOT_CYC clocks. While throttling with duty n, `stopClkN` is 0 exactly in slots n through 2^DUTY_W-1 of each period, counting slots from 0.
- R5: After the enable flag is set, `stopClkN` stays 1 until the first period boundary. The duty field in force at that boundary is then used for the whole period.
- R6: A duty field of 0 behaves as a duty of 1: one running slot per period.
- R7: If the duty field is rewritten while enabled, the old duty holds until the current period ends. The new duty starts with the next period.
- R8: With DUTY_W = 0, `stopClkN` stays 1 whatever is written, and the control word still reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Value to store in the control word |
| rdData | output | 32 | Current control word |
| stopClkN | output | 1 | Active-low stop-clock output |

## Verification
The hardest case to reach from the ports is a duty rewrite or an enable change that lands at an arbitrary phase of the free-running period. This matters most when the write falls just before or on the last cycle of a period, where a boundary load and a register update meet. A bench model follows the period phase from reset. Directed sequences set each duty value and rewrite the duty mid-period. Thousands of cycles of seeded random writes then hit the enable flag at every phase offset, including the boundary cycle itself.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  localparam int CTRL_W = 32;
  localparam int EN_BIT = 4;

  typedef enum logic {
    THR_IDLE   = 1'b0,
    THR_ACTIVE = 1'b1
  } thrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic runNext;   // throttling is active after this edge
    logic loadDuty;  // capture duty field at this period boundary
  } thrStrobe_t;
endpackage

// File: rtl/throttle_regfile.sv
module throttle_regfile
  import throttle_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlQ <= '0;
    else if (wrEn) ctrlQ <= wrData;
  end
endmodule

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import throttle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enBit,
  input  logic       periodEnd,
  output thrStrobe_t strobe
);
  thrState_t stateQ;

  always_comb begin
    strobe.loadDuty = enBit && periodEnd;
    strobe.runNext  = enBit && ((stateQ == THR_ACTIVE) || periodEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stateQ <= THR_IDLE;
    else if (strobe.runNext) stateQ <= THR_ACTIVE;
    else                     stateQ <= THR_IDLE;
  end
endmodule

// File: rtl/throttle_datapath.sv
module throttle_datapath
  import throttle_pkg::*;
#(
  parameter int DUTY_W   = 3,
  parameter int SLOT_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] dutyField,
  input  thrStrobe_t        strobe,
  output logic              periodEnd,
  output logic              stopClkN
);
  localparam int CYC_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYC - 1);
  localparam logic [DUTY_W-1:0] SLOT_LAST = '1;

  logic [CYC_W-1:0]  cycQ, cycNext;
  logic [DUTY_W-1:0] slotQ, slotNext;
  logic [DUTY_W-1:0] dutyQ, dutyNext, fieldDuty;
  logic              stopQ, stopNext, slotEnd;

  always_comb begin
    slotEnd   = (cycQ == CYC_LAST);
    periodEnd = slotEnd && (slotQ == SLOT_LAST);
    cycNext   = slotEnd ? '0 : cycQ + CYC_W'(1);
    slotNext  = slotEnd ? slotQ + DUTY_W'(1) : slotQ;
    fieldDuty = (dutyField == '0) ? DUTY_W'(1) : dutyField;
    dutyNext  = strobe.loadDuty ? fieldDuty : dutyQ;
    stopNext  = strobe.runNext && (slotNext >= dutyNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycQ  <= '0;
      slotQ <= '0;
      dutyQ <= DUTY_W'(1);
      stopQ <= 1'b0;
    end else begin
      cycQ  <= cycNext;
      slotQ <= slotNext;
      dutyQ <= dutyNext;
      stopQ <= stopNext;
    end
  end

  assign stopClkN = ~stopQ;
endmodule

// File: rtl/clk_throttle.sv
module clk_throttle
  import throttle_pkg::*;
#(
  parameter int DUTY_OFS = 5,
  parameter int DUTY_W   = 3,
  parameter int SLOT_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        stopClkN
);
  localparam int FIELD_TOP = DUTY_OFS + DUTY_W - 1;

  logic [CTRL_W-1:0] ctrlQ;

  throttle_regfile i_regs (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrData(wrData),
    .ctrlQ (ctrlQ)
  );

  assign rdData = ctrlQ;

  generate
    if (DUTY_W > 0) begin : g_thr
      if (FIELD_TOP > CTRL_W - 1 || (DUTY_OFS <= EN_BIT && FIELD_TOP >= EN_BIT)) begin : g_bad
        $error("duty field must fit in bits 31..0 and must not cover the enable bit");
      end

      thrStrobe_t        strobe;
      logic              periodEnd;
      logic [DUTY_W-1:0] dutyField;

      assign dutyField = ctrlQ[DUTY_OFS +: DUTY_W];

      throttle_ctrl i_ctrl (
        .clk      (clk),
        .rstN     (rstN),
        .enBit    (ctrlQ[EN_BIT]),
        .periodEnd(periodEnd),
        .strobe   (strobe)
      );

      throttle_datapath #(.DUTY_W(DUTY_W), .SLOT_CYC(SLOT_CYC)) i_dp (
        .clk      (clk),
        .rstN     (rstN),
        .dutyField(dutyField),
        .strobe   (strobe),
        .periodEnd(periodEnd),
        .stopClkN (stopClkN)
      );
    end else begin : g_none
      assign stopClkN = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/throttle_checker.sv
module throttle_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        stopClkN
);
  AST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData))); // R2

  AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[4] |=> stopClkN); // R3

  AST_STOP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    !stopClkN |-> $past(rdData[4])); // R4

  AST_ARM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[4]) |=> stopClkN); // R5
endmodule

bind clk_throttle throttle_checker i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .stopClkN(stopClkN)
);

// File: tb/test_clk_throttle.sv
module test_clk_throttle;
  localparam int OFS    = 5;
  localparam int W      = 3;
  localparam int SC     = 4;
  localparam int SLOTS  = 1 << W;
  localparam int PERIOD = SLOTS * SC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdData0;
  logic        stopClkN, stopClkN0;

  always #10 clk = ~clk;

  clk_throttle #(.DUTY_OFS(OFS), .DUTY_W(W), .SLOT_CYC(SC)) i_clk_throttle (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .stopClkN(stopClkN));

  clk_throttle #(.DUTY_OFS(OFS), .DUTY_W(0), .SLOT_CYC(SC)) i_noThr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData0), .stopClkN(stopClkN0));

  int    nChecks = 0;
  int    nFail = 0;
  string curTag = "";

  // reference model built from the requirements
  logic [31:0] mReg = '0;
  int          mPhase = 0;
  bit          mRun = 0;
  int          mDuty = 1;
  bit          mZero = 0;

  function automatic logic [31:0] ctrlWord(bit en, int duty, logic [31:0] fill);
    logic [31:0] w;
    w = fill;
    w[4] = en;
    w[OFS +: W] = duty[W-1:0];
    return w;
  endfunction

  function automatic int fieldOf(logic [31:0] r);
    return int'((r >> OFS) & (SLOTS - 1));
  endfunction

  function automatic bit expStopN();
    return !(mRun && ((mPhase / SC) >= mDuty));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit boundary, en;
    int f;
    boundary = (mPhase == PERIOD - 1);
    en = mReg[4];
    f = fieldOf(mReg);
    if (en && boundary) begin
      mDuty = (f == 0) ? 1 : f;
      mZero = (f == 0);
    end
    mRun = en && (mRun || boundary);
    if (wrEn) mReg = wrData;
    mPhase = (mPhase + 1) % PERIOD;
  endtask

  task automatic step();
    string tag;
    @(posedge clk);
    if (rstN) modelEdge();
    else begin
      mReg = '0; mPhase = 0; mRun = 0; mDuty = 1; mZero = 0;
    end
    @(negedge clk);
    if (!rstN) tag = "R1";
    else if (curTag != "") tag = curTag;
    else if (!mRun && mReg[4]) tag = "R5";
    else if (!mRun) tag = "R3";
    else if (mZero) tag = "R6";
    else tag = "R4";
    check(tag, {31'd0, stopClkN}, {31'd0, expStopN()});
    check(rstN ? "R2" : "R1", rdData, mReg);
    check("R8", {31'd0, stopClkN0}, 32'd1);
    check("R8", rdData0, mReg);
  endtask

  task automatic write(logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    idle(3);                        // R1 reset state
    rstN = 1'b1;
    idle(2);
    // R2 read back with enable clear, odd bit patterns
    write(32'hFFFF_FFEF); idle(1);
    write(32'h1234_5600); idle(1);
    write(32'h8000_0001); idle(1);
    // R4 / R6 three-write sequence for every duty value
    for (int d = 0; d < SLOTS; d++) begin
      write(ctrlWord(0, d, 32'h0));
      write(ctrlWord(0, d, 32'hA000_0000));
      write(ctrlWord(1, d, 32'hA000_0000));
      idle(2 * PERIOD + 5);
    end
    // R7 rewrite duty while enabled
    write(ctrlWord(1, 2, 32'h0));
    idle(PERIOD + 11);
    curTag = "R7";
    write(ctrlWord(1, 6, 32'h0));
    idle(2 * PERIOD);
    curTag = "";
    // R3 disable while the pin is low
    write(ctrlWord(1, 1, 32'h0));
    idle(PERIOD);
    while (expStopN()) step();
    idle(2);
    curTag = "R3";
    write(ctrlWord(0, 1, 32'h0));
    idle(PERIOD);
    curTag = "";
    // random writes at arbitrary phases
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 12) == 0) write($urandom);
      else step();
    end
    // R8 all ones with enable set on the no-throttle instance
    write(32'hFFFF_FFFF);
    idle(2 * PERIOD);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule